// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block computes the 16-bit operand address for an 8-bit processor core with a 16-bit address space. Each cycle it can accept one request. A request gives a mode, up to two register selectors, a displacement and a width flag. The block reads the current values of the HL, IX, IY, SP and PC registers from its inputs. The sum is produced by one adder and registered. One cycle after the request, the result appears with a valid pulse, and the request's mode is returned alongside it.

Four modes are available:
- **Indexed:** a displacement added to HL, IX or IY.
- **PC-relative:** a displacement added to PC.
- **SP-relative:** a displacement added to SP.
- **Base-index:** the sum of two different registers taken from HL, IX and IY.

A request whose selectors cannot form a legal address is refused. In that case the block raises a one-cycle illegal flag instead of a valid pulse.

The block covers address computation only. Decoding the instruction, accessing memory and writing registers back are all done elsewhere.

Top module: `eag_top`

## Requirements
- R1: With `reqMode`=00 (indexed), the base is chosen by `selA` (00 HL, 01 IX, 10 IY), and the displacement is added to it.
- R2: With `dispWide`=0, only `disp[7:0]` is used, and it is sign-extended to 16 bits. With `dispWide`=1, all 16 bits of `disp` are added unchanged.
- R3: With `reqMode`=01, the address is `regPc` plus the displacement.
- R4: With `reqMode`=10, the address is `regSp` plus the displacement. SP itself is only read, never changed.
- R5: With `reqMode`=11 (base-index), the address is the sum of the registers named by `selA` and `selB`, using the R1 encoding. The displacement is ignored in this mode.
- R6: Every sum wraps modulo 2^16, and no carry is reported.
- R7: A request is illegal in either of these cases: a selector used by the mode holds code 11, or base-index has `selA` equal to `selB`. An illegal request gives `outIllegal`=1 and `outValid`=0 for one cycle, and `outAddr` keeps its previous value.
- R8: A legal request sampled at a rising edge gives `outValid`=1 for exactly the following cycle, with `outMode` equal to the request's mode. A cycle without a request gives neither `outValid` nor `outIllegal` in the next cycle.
- R9: After reset, `outValid`, `outIllegal`, `outAddr` and `outMode` are all zero.
- R10: `outAddr` changes only after a legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqMode | input | 2 | Mode: 00 indexed, 01 PC-rel, 10 SP-rel, 11 base-index |
| selA | input | 2 | First register selector |
| selB | input | 2 | Second register selector (base-index only) |
| dispWide | input | 1 | 1 = 16-bit displacement, 0 = 8-bit |
| disp | input | 16 | Displacement |
| regHl | input | 16 | HL value |
| regIx | input | 16 | IX value |
| regIy | input | 16 | IY value |
| regSp | input | 16 | SP value |
| regPc | input | 16 | PC value |
| outValid | output | 1 | Result valid pulse |
| outIllegal | output | 1 | Illegal request pulse |
| outAddr | output | 16 | Effective address |
| outMode | output | 2 | Mode of the last answered request |

## Verification
The assertions assume that the register and displacement inputs are stable at the rising edge where `reqValid` is sampled. They check the registered result against the values sampled one cycle earlier, so no timing assumption beyond that edge is needed.

The stimulus drives all inputs at the falling edge. It holds them through the next rising edge, then samples the outputs at the following falling edge. Random requests cover every mode and selector code, including the code 11 and same-register cases. Directed cases cover wrap-around and sign-extension extremes.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_INDEXED = 2'b00,
    MODE_PC_REL  = 2'b01,
    MODE_SP_REL  = 2'b10,
    MODE_BASEIDX = 2'b11
  } addrMode_t;

  typedef enum logic [SEL_W-1:0] {
    RSEL_HL  = 2'b00,
    RSEL_IX  = 2'b01,
    RSEL_IY  = 2'b10,
    RSEL_BAD = 2'b11
  } regSel_t;

  typedef enum logic [2:0] {
    BASE_HL = 3'd0,
    BASE_IX = 3'd1,
    BASE_IY = 3'd2,
    BASE_SP = 3'd3,
    BASE_PC = 3'd4
  } baseSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      capture;      // legal request: load address
    logic      flagIllegal;  // refused request
    baseSel_t  baseSel;      // first operand
    logic      addReg;       // second operand is a register, not disp
    regSel_t   otherSel;     // register for second operand
    addrMode_t mode;         // mode to echo
  } eagStrobe_t;

endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic             reqValid,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [SEL_W-1:0] selA,
  input  logic [SEL_W-1:0] selB,
  output eagStrobe_t       strobe
);

  function automatic baseSel_t mapSel(input logic [SEL_W-1:0] s);
    case (s)
      RSEL_IX: mapSel = BASE_IX;
      RSEL_IY: mapSel = BASE_IY;
      default: mapSel = BASE_HL;
    endcase
  endfunction

  logic selAOk;
  logic selBOk;
  logic legal;

  always_comb begin
    selAOk = (selA != RSEL_BAD);
    selBOk = (selB != RSEL_BAD) && (selB != selA);
    strobe = '0;
    strobe.mode     = addrMode_t'(reqMode);
    strobe.otherSel = regSel_t'(selB);
    legal = 1'b1;
    case (addrMode_t'(reqMode))
      MODE_INDEXED: begin
        legal          = selAOk;
        strobe.baseSel = mapSel(selA);
      end
      MODE_PC_REL: strobe.baseSel = BASE_PC;
      MODE_SP_REL: strobe.baseSel = BASE_SP;
      default: begin
        legal          = selAOk && selBOk;
        strobe.baseSel = mapSel(selA);
        strobe.addReg  = 1'b1;
      end
    endcase
    strobe.capture     = reqValid && legal;
    strobe.flagIllegal = reqValid && !legal;
  end

endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DISP_NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eagStrobe_t        strobe,
  input  logic              dispWide,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] regHl,
  input  logic [ADDR_W-1:0] regIx,
  input  logic [ADDR_W-1:0] regIy,
  input  logic [ADDR_W-1:0] regSp,
  input  logic [ADDR_W-1:0] regPc,
  output logic              outValid,
  output logic              outIllegal,
  output logic [ADDR_W-1:0] outAddr,
  output logic [MODE_W-1:0] outMode
);

  localparam int EXT_W = ADDR_W - DISP_NARROW_W;

  logic [ADDR_W-1:0] narrowExt;
  logic [ADDR_W-1:0] dispVal;
  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] otherVal;
  logic [ADDR_W-1:0] offsVal;
  logic [ADDR_W-1:0] sum;

  generate
    if (EXT_W > 0) begin : g_signExt
      assign narrowExt = {{EXT_W{disp[DISP_NARROW_W-1]}}, disp[DISP_NARROW_W-1:0]};
    end else begin : g_noExt
      assign narrowExt = disp;
    end
  endgenerate

  assign dispVal = dispWide ? disp : narrowExt;

  always_comb begin
    case (strobe.baseSel)
      BASE_IX: baseVal = regIx;
      BASE_IY: baseVal = regIy;
      BASE_SP: baseVal = regSp;
      BASE_PC: baseVal = regPc;
      default: baseVal = regHl;
    endcase
  end

  always_comb begin
    case (strobe.otherSel)
      RSEL_IX: otherVal = regIx;
      RSEL_IY: otherVal = regIy;
      default: otherVal = regHl;
    endcase
  end

  assign offsVal = strobe.addReg ? otherVal : dispVal;
  assign sum     = baseVal + offsVal;   // wraps modulo 2^ADDR_W

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outAddr    <= '0;
      outMode    <= '0;
    end else begin
      outValid   <= strobe.capture;
      outIllegal <= strobe.flagIllegal;
      if (strobe.capture) outAddr <= sum;
      if (strobe.capture || strobe.flagIllegal) outMode <= strobe.mode;
    end
  end

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DISP_NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqMode,
  input  logic [1:0]        selA,
  input  logic [1:0]        selB,
  input  logic              dispWide,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] regHl,
  input  logic [ADDR_W-1:0] regIx,
  input  logic [ADDR_W-1:0] regIy,
  input  logic [ADDR_W-1:0] regSp,
  input  logic [ADDR_W-1:0] regPc,
  output logic              outValid,
  output logic              outIllegal,
  output logic [ADDR_W-1:0] outAddr,
  output logic [1:0]        outMode
);

  eagStrobe_t strobe;

  eag_ctrl i_ctrl (
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .selA     (selA),
    .selB     (selB),
    .strobe   (strobe)
  );

  eag_datapath #(
    .ADDR_W        (ADDR_W),
    .DISP_NARROW_W (DISP_NARROW_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dispWide   (dispWide),
    .disp       (disp),
    .regHl      (regHl),
    .regIx      (regIx),
    .regIy      (regIy),
    .regSp      (regSp),
    .regPc      (regPc),
    .outValid   (outValid),
    .outIllegal (outIllegal),
    .outAddr    (outAddr),
    .outMode    (outMode)
  );

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqMode,
  input logic [1:0]        selA,
  input logic [1:0]        selB,
  input logic              dispWide,
  input logic [ADDR_W-1:0] disp,
  input logic [ADDR_W-1:0] regPc,
  input logic [ADDR_W-1:0] regSp,
  input logic              outValid,
  input logic              outIllegal,
  input logic [ADDR_W-1:0] outAddr,
  input logic [1:0]        outMode
);

  AST_NO_REQ_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!outValid && !outIllegal)); // R8

  AST_VALID_XOR_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outIllegal)); // R7

  AST_SAME_REG_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'b11 && selA == selB) |=> (outIllegal && !outValid)); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outAddr) || $past(!rstN)); // R10

  AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid) |=> (outMode == $past(reqMode))); // R8

  AST_PC_REL_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'b01 && dispWide) |=>
      (outValid && outAddr == $past(regPc) + $past(disp))); // R3

  AST_SP_REL_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'b10 && dispWide) |=>
      (outValid && outAddr == $past(regSp) + $past(disp))); // R4

endmodule

bind eag_top eag_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqMode    (reqMode),
  .selA       (selA),
  .selB       (selB),
  .dispWide   (dispWide),
  .disp       (disp),
  .regPc      (regPc),
  .regSp      (regSp),
  .outValid   (outValid),
  .outIllegal (outIllegal),
  .outAddr    (outAddr),
  .outMode    (outMode)
);

// File: tb/test_eag_top.sv
`timescale 1ns/1ps
module test_eag_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = '0;
  logic [1:0]  selA = '0;
  logic [1:0]  selB = '0;
  logic        dispWide = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] regHl = '0, regIx = '0, regIy = '0, regSp = '0, regPc = '0;
  logic        outValid, outIllegal;
  logic [15:0] outAddr;
  logic [1:0]  outMode;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] lastAddr = '0;

  always #2 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .selA(selA), .selB(selB), .dispWide(dispWide), .disp(disp),
    .regHl(regHl), .regIx(regIx), .regIy(regIy), .regSp(regSp), .regPc(regPc),
    .outValid(outValid), .outIllegal(outIllegal), .outAddr(outAddr), .outMode(outMode)
  );

  function automatic logic [15:0] pickReg(input logic [1:0] s);
    case (s)
      2'b00: return regHl;
      2'b01: return regIx;
      default: return regIy;
    endcase
  endfunction

  function automatic logic legalReq(input logic [1:0] m, input logic [1:0] a, input logic [1:0] b);
    if (m == 2'b00) return a != 2'b11;
    if (m == 2'b11) return (a != 2'b11) && (b != 2'b11) && (a != b);
    return 1'b1;
  endfunction

  function automatic logic [15:0] expAddr(input logic [1:0] m, input logic [1:0] a,
                                          input logic [1:0] b, input logic w,
                                          input logic [15:0] d);
    logic [15:0] dv;
    dv = w ? d : {{8{d[7]}}, d[7:0]};
    case (m)
      2'b00: return pickReg(a) + dv;
      2'b01: return regPc + dv;
      2'b10: return regSp + dv;
      default: return pickReg(a) + pickReg(b);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a request at a falling edge, sample at the next falling edge.
  task automatic doReq(input string req, input logic [1:0] m, input logic [1:0] a,
                       input logic [1:0] b, input logic w, input logic [15:0] d);
    logic ok;
    logic [15:0] e;
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; selA = a; selB = b; dispWide = w; disp = d;
    ok = legalReq(m, a, b);
    e  = expAddr(m, a, b, w, d);
    @(negedge clk);
    reqValid = 1'b0;
    if (ok) begin
      check({req, " valid"}, {31'd0, outValid}, 32'd1);
      check({req, " addr"}, {16'd0, outAddr}, {16'd0, e});
      lastAddr = e;
    end else begin
      check({req, " R7 illegal"}, {30'd0, outIllegal, outValid}, 32'd2);
      check({req, " R7 addr held"}, {16'd0, outAddr}, {16'd0, lastAddr});
    end
    check({req, " R8 mode echo"}, {30'd0, outMode}, {30'd0, m});
  endtask

  function automatic string tagFor(input logic [1:0] m, input logic w);
    string t;
    case (m)
      2'b00: t = "R1";
      2'b01: t = "R3";
      2'b10: t = "R4";
      default: t = "R5";
    endcase
    return w ? t : {t, "/R2"};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0A11));
    regHl = 16'h1234; regIx = 16'h8000; regIy = 16'hFFF0; regSp = 16'hFF00; regPc = 16'h0100;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {13'd0, outValid, outIllegal, outMode, outAddr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle no pulse", {30'd0, outValid, outIllegal}, 32'd0);

    doReq("R1 HL wide", 2'b00, 2'b00, 2'b00, 1'b1, 16'h0100);
    doReq("R1 IX narrow", 2'b00, 2'b01, 2'b00, 1'b0, 16'h0005);
    doReq("R2 narrow negative", 2'b00, 2'b10, 2'b00, 1'b0, 16'hAB80);
    doReq("R2 wide ignores sign", 2'b00, 2'b00, 2'b00, 1'b1, 16'h0080);
    doReq("R3 PC narrow -1", 2'b01, 2'b00, 2'b00, 1'b0, 16'h00FF);
    doReq("R4 SP wrap R6", 2'b10, 2'b00, 2'b00, 1'b1, 16'h0100);
    doReq("R5 IX+IY R6", 2'b11, 2'b01, 2'b10, 1'b1, 16'h7777);
    doReq("R7 same reg", 2'b11, 2'b00, 2'b00, 1'b0, 16'h0000);
    doReq("R7 sel 11 indexed", 2'b00, 2'b11, 2'b00, 1'b1, 16'h0001);
    doReq("R7 selB 11", 2'b11, 2'b00, 2'b11, 1'b1, 16'h0001);
    @(negedge clk);
    check("R8 one-cycle pulse", {30'd0, outValid, outIllegal}, 32'd0);
    check("R10 addr held idle", {16'd0, outAddr}, {16'd0, lastAddr});

    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      logic w;
      m = 2'($urandom);
      w = 1'($urandom);
      regHl = 16'($urandom); regIx = 16'($urandom); regIy = 16'($urandom);
      regSp = 16'($urandom); regPc = 16'($urandom);
      doReq(tagFor(m, w), m, 2'($urandom), 2'($urandom), w, 16'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule